// File: doc/BRIEF.md
# Byte FIFO with Threshold Flag

A 16-byte staging buffer placed between a 32-bit host access port and the byte-serial data phase of a serial flash controller. The host side takes or delivers 1, 2 or 4 bytes per access through a valid/ready handshake with a size code. The engine side moves one byte at a time. A direction input decides which side fills the buffer. In write direction the host fills and the engine drains. In read direction the engine fills and the host drains.

The block reports how many bytes it holds. It raises a threshold flag whose test depends on the direction: free space in write direction, held bytes in read direction. It also flags leftover bytes once the flash read has finished. Host accesses that cannot complete are held off with ready low. A read waiting on data is released early when the transfer-done input rises; the bytes it could not get come back as zero. A synchronous flush input discards the contents and clears the flag.

Top module: `xfer_byte_fifo`

## Requirements
- R1: `level_o` gives the number of bytes held, from 0 (empty) to 16 (full), and reads 0 after reset.
- R2: The size code gives the byte count of a host access: 00 = 1, 01 = 2, 10 or 11 = 4. In write direction an accepted access appends that many bytes taken from `hst_wdata_i`, byte k from bits [8k+7:8k] with k = 0 first. The engine drains the bytes in that order on `eng_rdata_o`.
- R3: In read direction `hst_rdata_o` holds the oldest byte in bits [7:0], the next in [15:8] and so on. Bytes beyond the access size read as zero, and an accepted read removes that many bytes.
- R4: In write direction `hst_ready_o` is high exactly when the free space (16 − level) is at least the access size.
- R5: In read direction `hst_ready_o` is high exactly when the level is at least the access size or `xfer_done_i` is high.
- R6: A read accepted with `xfer_done_i` high and fewer bytes held than requested returns the held bytes followed by zero bytes, and leaves the level at 0.
- R7: In write direction, after each clock edge `thr_flag_o` is 1 exactly when the free space is at least `thr_i` + 1.
- R8: In read direction, after each clock edge `thr_flag_o` is 1 exactly when the level is at least `thr_i` + 1, or when `xfer_done_i` is high and the level is nonzero.
- R9: After a clock edge with `flush_i` high, the level is 0 and `thr_flag_o` is 0, and earlier contents are never delivered again.
- R10: An engine push is taken only in read direction with the buffer not full, and an engine pop only in write direction with it not empty. `eng_space_o` and `eng_avail_o` report those conditions. A push in write direction or a pop in read direction leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous discard of all contents |
| dir_rd_i | input | 1 | 1 = read direction (engine fills), 0 = write direction (host fills) |
| xfer_done_i | input | 1 | Flash-side transfer finished |
| thr_i | input | 5 | Threshold setting |
| hst_valid_i | input | 1 | Host access request |
| hst_size_i | input | 2 | Host access size code |
| hst_wdata_i | input | 32 | Host write data, low bytes used first |
| hst_ready_o | output | 1 | Host access completes this cycle |
| hst_rdata_o | output | 32 | Host read data, zero padded |
| eng_push_i | input | 1 | Engine writes one byte |
| eng_wdata_i | input | 8 | Engine write byte |
| eng_space_o | output | 1 | Engine push would be taken |
| eng_pop_i | input | 1 | Engine takes one byte |
| eng_rdata_o | output | 8 | Oldest byte, for the engine |
| eng_avail_o | output | 1 | Engine pop would be taken |
| level_o | output | 6 | Bytes held |
| thr_flag_o | output | 1 | Threshold flag |

## Verification
Ready, host read data and the engine byte depend on the current state and inputs without a register. The bench checks them 2 ns after driving its inputs at the falling edge, within the same cycle. Level and flag are registered. The bench checks them 5 ns after the next rising edge, once per access, against a byte-queue model updated with the same acceptance rules. Sweeps cover all three sizes against several thresholds in both directions, including stalls when full, stalls when short, early completion, and accesses issued to the wrong side.

// File: rtl/xbf_pkg.sv
package xbf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } hsize_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (hsize_e'(s))
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/xbf_ctrl.sv
module xbf_ctrl #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             dir_rd_i,
  input  logic             done_i,
  input  logic             hst_valid_i,
  input  logic [1:0]       hst_size_i,
  input  logic             eng_push_i,
  input  logic             eng_pop_i,
  output logic             hst_ready_o,
  output logic             eng_space_o,
  output logic             eng_avail_o,
  output logic [CNT_W-1:0] wcnt_o,
  output logic [CNT_W-1:0] rcnt_o,
  output logic [CNT_W-1:0] take_o,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] level_d_o
);
  logic [LVL_W-1:0] level_q, free, n_ext;
  logic [CNT_W-1:0] n_req;
  logic wr_ok, rd_ok, fire, e_push, e_pop;

  always_comb begin
    n_req  = CNT_W'(xbf_pkg::size_bytes(hst_size_i));
    n_ext  = LVL_W'(n_req);
    free   = LVL_W'(DEPTH) - level_q;
    // level below n_ext means it fits in CNT_W
    take_o = (level_q >= n_ext) ? n_req : CNT_W'(level_q);
    wr_ok  = free >= n_ext;
    rd_ok  = (level_q >= n_ext) || done_i;
    hst_ready_o = !flush_i && (dir_rd_i ? rd_ok : wr_ok);
    fire   = hst_valid_i && hst_ready_o;
    e_push = !flush_i && dir_rd_i && eng_push_i && (level_q != LVL_W'(DEPTH));
    e_pop  = !flush_i && !dir_rd_i && eng_pop_i && (level_q != '0);
    wcnt_o = dir_rd_i ? CNT_W'(e_push) : (fire ? n_req : '0);
    rcnt_o = dir_rd_i ? (fire ? take_o : '0) : CNT_W'(e_pop);
    level_d_o = flush_i ? '0 : level_q + LVL_W'(wcnt_o) - LVL_W'(rcnt_o);
  end

  assign eng_space_o = dir_rd_i && (level_q != LVL_W'(DEPTH));
  assign eng_avail_o = !dir_rd_i && (level_q != '0);
  assign level_o     = level_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d_o;
endmodule

// File: rtl/xbf_store.sv
module xbf_store #(
  parameter int DEPTH = 16,
  parameter int NB    = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             dir_rd_i,
  input  logic [CNT_W-1:0] wcnt_i,
  input  logic [CNT_W-1:0] rcnt_i,
  input  logic [CNT_W-1:0] take_i,
  input  logic [8*NB-1:0]  hst_wdata_i,
  input  logic [7:0]       eng_wdata_i,
  output logic [8*NB-1:0]  hst_rdata_o,
  output logic [7:0]       eng_rdata_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int NB_W  = $clog2(NB);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [7:0] wbyte [NB];
  logic [7:0] mem   [DEPTH];

  for (genvar k = 0; k < NB; k++) begin : g_wb
    assign wbyte[k] = dir_rd_i ? eng_wdata_i : hst_wdata_i[8*k +: 8];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [7:0]       cell_q;
    logic [PTR_W-1:0] ofs;
    assign ofs    = PTR_W'(i) - wr_ptr_q;
    assign mem[i] = cell_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) cell_q <= '0;
      else if (!flush_i && (ofs < PTR_W'(wcnt_i))) cell_q <= wbyte[ofs[NB_W-1:0]];
  end

  for (genvar k = 0; k < NB; k++) begin : g_rd
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr_q + PTR_W'(k);
    assign hst_rdata_o[8*k +: 8] = (CNT_W'(k) < take_i) ? mem[idx] : 8'h00;
  end

  assign eng_rdata_o = mem[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(wcnt_i);
      rd_ptr_q <= rd_ptr_q + PTR_W'(rcnt_i);
    end
endmodule

// File: rtl/xbf_thresh.sv
module xbf_thresh #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 6,
  parameter int THR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             dir_rd_i,
  input  logic             done_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [LVL_W-1:0] level_d_i,
  output logic             flag_o
);
  localparam int CW = ((LVL_W > THR_W) ? LVL_W : THR_W) + 2;

  logic [CW-1:0] lim, held, room;
  logic cond;

  always_comb begin
    lim  = CW'(thr_i) + CW'(1);
    held = CW'(level_d_i);
    room = CW'(DEPTH) - held;
    cond = dir_rd_i ? ((held >= lim) || (done_i && (held != '0)))
                    : (room >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      flag_o <= 1'b0;
    else if (flush_i) flag_o <= 1'b0;
    else              flag_o <= cond;
endmodule

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int THR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             dir_rd_i,
  input  logic             xfer_done_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             hst_valid_i,
  input  logic [1:0]       hst_size_i,
  input  logic [DW-1:0]    hst_wdata_i,
  output logic             hst_ready_o,
  output logic [DW-1:0]    hst_rdata_o,
  input  logic             eng_push_i,
  input  logic [7:0]       eng_wdata_i,
  output logic             eng_space_o,
  input  logic             eng_pop_i,
  output logic [7:0]       eng_rdata_o,
  output logic             eng_avail_o,
  output logic [$clog2(DEPTH)+1:0] level_o,
  output logic             thr_flag_o
);
  localparam int NB    = DW / 8;
  localparam int CNT_W = $clog2(NB + 1);
  localparam int LVL_W = $clog2(DEPTH) + 2;

  logic [CNT_W-1:0] wcnt, rcnt, take;
  logic [LVL_W-1:0] level_d;

  xbf_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .flush_i, .dir_rd_i,
    .done_i      (xfer_done_i),
    .hst_valid_i, .hst_size_i, .eng_push_i, .eng_pop_i,
    .hst_ready_o, .eng_space_o, .eng_avail_o,
    .wcnt_o      (wcnt),
    .rcnt_o      (rcnt),
    .take_o      (take),
    .level_o,
    .level_d_o   (level_d)
  );

  xbf_store #(.DEPTH(DEPTH), .NB(NB), .CNT_W(CNT_W)) u_store (
    .clk_i, .rst_ni, .flush_i, .dir_rd_i,
    .wcnt_i      (wcnt),
    .rcnt_i      (rcnt),
    .take_i      (take),
    .hst_wdata_i, .eng_wdata_i, .hst_rdata_o, .eng_rdata_o
  );

  xbf_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) u_thresh (
    .clk_i, .rst_ni, .flush_i, .dir_rd_i,
    .done_i      (xfer_done_i),
    .thr_i,
    .level_d_i   (level_d),
    .flag_o      (thr_flag_o)
  );
endmodule

// File: rtl/xfer_byte_fifo_chk.sv
module xfer_byte_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             dir_rd_i,
  input logic             xfer_done_i,
  input logic             hst_valid_i,
  input logic [1:0]       hst_size_i,
  input logic             hst_ready_o,
  input logic             eng_push_i,
  input logic             eng_pop_i,
  input logic [LVL_W-1:0] level_o,
  input logic             thr_flag_o
);
  logic [LVL_W-1:0] n_c;
  assign n_c = LVL_W'(xbf_pkg::size_bytes(hst_size_i));

  a_r1_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  a_r2_write_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rd_i && hst_valid_i && hst_ready_o && !eng_pop_i && !flush_i)
    |=> level_o == $past(level_o) + $past(n_c));

  a_r4_write_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rd_i && hst_valid_i && (LVL_W'(DEPTH) - level_o) < n_c) |-> !hst_ready_o);

  a_r5_read_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rd_i && hst_valid_i && !xfer_done_i && level_o < n_c) |-> !hst_ready_o);

  a_r6_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rd_i && hst_valid_i && hst_ready_o && xfer_done_i && level_o < n_c && !flush_i)
    |=> level_o <= LVL_W'(1));

  a_r9_flush_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0) && !thr_flag_o);

  a_r10_push_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rd_i && eng_push_i && !hst_valid_i && !eng_pop_i && !flush_i) |=> $stable(level_o));
endmodule

bind xfer_byte_fifo xfer_byte_fifo_chk #(.DEPTH(DEPTH), .LVL_W($clog2(DEPTH)+2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .dir_rd_i(dir_rd_i),
  .xfer_done_i(xfer_done_i), .hst_valid_i(hst_valid_i), .hst_size_i(hst_size_i),
  .hst_ready_o(hst_ready_o), .eng_push_i(eng_push_i), .eng_pop_i(eng_pop_i),
  .level_o(level_o), .thr_flag_o(thr_flag_o)
);

// File: tb/xfer_byte_fifo_test.sv
module xfer_byte_fifo_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        flush_i = 0, dir_rd_i = 1, xfer_done_i = 0;
  logic [4:0]  thr_i = 0;
  logic        hst_valid_i = 0;
  logic [1:0]  hst_size_i = 0;
  logic [31:0] hst_wdata_i = 0;
  logic        hst_ready_o;
  logic [31:0] hst_rdata_o;
  logic        eng_push_i = 0, eng_pop_i = 0;
  logic [7:0]  eng_wdata_i = 0;
  logic        eng_space_o, eng_avail_o;
  logic [7:0]  eng_rdata_o;
  logic [5:0]  level_o;
  logic        thr_flag_o;

  int n_chk = 0, n_fail = 0, seed = 1;
  logic [7:0] mq[$];

  always #10 clk_i = ~clk_i;

  xfer_byte_fifo uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic bit exp_flag(input int cnt);
    if (dir_rd_i) return (cnt >= int'(thr_i) + 1) || (xfer_done_i && cnt > 0);
    return (16 - cnt) >= int'(thr_i) + 1;
  endfunction

  task automatic step(input bit hv, input logic [1:0] hs, input bit ep, input bit eo);
    int n, cnt, take;
    bit rdy;
    logic [31:0] hw, er;
    logic [7:0] ed;
    n   = (hs == 2'd0) ? 1 : (hs == 2'd1) ? 2 : 4;
    cnt = mq.size();
    hw  = {8'(seed + 3), 8'(seed + 2), 8'(seed + 1), 8'(seed)};
    ed  = 8'(seed + 128);
    seed += 4;
    @(negedge clk_i);
    hst_valid_i = hv; hst_size_i = hs; hst_wdata_i = hw;
    eng_push_i = ep; eng_wdata_i = ed; eng_pop_i = eo;
    #2;
    rdy = dir_rd_i ? (cnt >= n || xfer_done_i) : (16 - cnt >= n);
    if (hv) chk(hst_ready_o == rdy, dir_rd_i ? "R5" : "R4", 32'(hst_ready_o), 32'(rdy));
    if (hv && dir_rd_i) begin
      er = '0;
      for (int k = 0; k < 4; k++) if (k < n && k < cnt) er[8*k +: 8] = mq[k];
      chk(hst_rdata_o == er, (cnt < n) ? "R6" : "R3", hst_rdata_o, er);
    end
    if (!dir_rd_i && cnt > 0) chk(eng_rdata_o == mq[0], "R2", 32'(eng_rdata_o), 32'(mq[0]));
    chk(eng_space_o == (dir_rd_i && cnt < 16), "R10", 32'(eng_space_o), 32'(dir_rd_i && cnt < 16));
    chk(eng_avail_o == (!dir_rd_i && cnt > 0), "R10", 32'(eng_avail_o), 32'(!dir_rd_i && cnt > 0));
    // model update
    if (dir_rd_i) begin
      take = (hv && rdy) ? ((n < cnt) ? n : cnt) : 0;
      for (int k = 0; k < take; k++) void'(mq.pop_front());
      if (ep && cnt < 16) mq.push_back(ed);
    end else begin
      if (eo && cnt > 0) void'(mq.pop_front());
      if (hv && rdy) for (int k = 0; k < n; k++) mq.push_back(hw[8*k +: 8]);
    end
    @(posedge clk_i); #5;
    hst_valid_i = 0; eng_push_i = 0; eng_pop_i = 0;
    chk(level_o == 6'(mq.size()), "R1", 32'(level_o), 32'(mq.size()));
    chk(thr_flag_o == exp_flag(mq.size()), dir_rd_i ? "R8" : "R7", 32'(thr_flag_o),
        32'(exp_flag(mq.size())));
  endtask

  task automatic flush();
    @(negedge clk_i); flush_i = 1;
    @(posedge clk_i); #5; flush_i = 0;
    mq.delete();
    chk(level_o == 0, "R9", 32'(level_o), 0);
    chk(thr_flag_o == 0, "R9", 32'(thr_flag_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int thr_list[5];
    repeat (3) @(negedge clk_i);
    rst_ni = 1; #2;
    chk(level_o == 0, "R1", 32'(level_o), 0);
    chk(thr_flag_o == 0, "R8", 32'(thr_flag_o), 0);

    // write direction: fill each size against several thresholds, then drain
    thr_list = '{0, 5, 12, 16, 31};
    dir_rd_i = 0;
    for (int s = 0; s < 4; s++)
      foreach (thr_list[t]) begin
        thr_i = 5'(thr_list[t]);
        flush();
        for (int i = 0; i < 10; i++) step(1, 2'(s), 0, 0);
        for (int i = 0; i < 18; i++) step(0, 0, 0, 1);
      end
    // write and drain in the same cycle, then pushes from the wrong side
    thr_i = 3;
    flush();
    for (int i = 0; i < 8; i++) step(1, 2'(i % 3), 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0);   // R10 push ignored
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1);

    // read direction
    dir_rd_i = 1;
    thr_list = '{0, 3, 7, 15, 16};
    foreach (thr_list[t]) begin
      thr_i = 5'(thr_list[t]);
      xfer_done_i = 0;
      flush();
      for (int i = 0; i < 20; i++) step(0, 0, 1, 0);
      step(0, 0, 0, 1);                          // R10 pop ignored
      for (int i = 0; i < 8; i++) step(1, 2'(i % 3), 0, 0);
      xfer_done_i = 1;
      step(0, 0, 0, 0);                          // R8 leftover flag
      step(1, 2'd2, 0, 0);                       // R6 early completion
      step(1, 2'd1, 0, 0);
      xfer_done_i = 0;
    end
    // reads while the engine pushes
    thr_i = 4;
    flush();
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0);
    for (int i = 0; i < 6; i++) step(1, 2'(i % 3), 1, 0);
    // flush discards contents (R9)
    flush();
    xfer_done_i = 1;
    step(1, 2'd2, 0, 0);
    xfer_done_i = 0;
    finish_run();
  end
endmodule